// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler Chain

This block turns a free-running system clock into three single-cycle enable strobes for the fast-bus and two peripheral-bus domains. It contains no clock gating. Logic in each domain runs on the system clock and advances only on cycles where its strobe is high. A programmable divider makes the fast-bus (AHB) strobe from the system clock. Two further dividers make the peripheral-bus (APB) strobes. They count AHB strobes, not system clock cycles, so each peripheral rate is a fraction of the AHB rate.

A 10-bit configuration word is loaded through a write-enable. Each divider works from its own copy of the ratio it is using. It takes a new ratio only when it reaches its terminal count, so an enable period is never cut short. The ratios in effect are returned as base-2 exponents.

Top module: `busclk_prescaler`

## Requirements
- R1: After reset is released, every ratio in effect is 1: `ahb_en`, `apb1_en` and `apb2_en` are high on the first cycle out of reset, and all read-back exponents are 0.
- R2: The AHB field decodes as follows. Any code with bit 3 clear gives divide by 1. Codes 1000, 1001, 1010 and 1011 give /2, /4, /8 and /16. Codes 1100, 1101, 1110 and 1111 give /64, /128, /256 and /512. Once a ratio is in effect, `ahb_en` is high for exactly one cycle in each group of that many system clock cycles.
- R3: No AHB code gives divide by 32. Code 1011 reads back exponent 4, and code 1100 reads back exponent 6.
- R4: Each APB field decodes as follows. Any code with bit 2 clear gives divide by 1. Codes 100, 101, 110 and 111 give /2, /4, /8 and /16.
- R5: Each APB divider counts AHB strobes. With AHB ratio H and APB ratio P, the APB strobe repeats every H·P system clock cycles.
- R6: `apb1_en` and `apb2_en` are high only on cycles where `ahb_en` is also high.
- R7: When `cfg_we` is high at a clock edge, `cfg_data` is stored. The layout is: bits [3:0] AHB field, bits [6:4] APB1 field, bits [9:7] APB2 field.
- R8: A new ratio takes effect only at the divider's next terminal count. The strobe period that is running when the write arrives completes at its old length.
- R9: `ahb_shift`, `apb1_shift` and `apb2_shift` give the base-2 exponent of the ratio each divider is currently using. Each one changes only on the cycle after that divider's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load enable for the configuration word |
| cfg_data | input | 10 | Configuration word: AHB [3:0], APB1 [6:4], APB2 [9:7] |
| ahb_en | output | 1 | AHB-domain enable strobe |
| apb1_en | output | 1 | APB1-domain enable strobe |
| apb2_en | output | 1 | APB2-domain enable strobe |
| ahb_shift | output | 4 | Exponent of the AHB ratio in effect |
| apb1_shift | output | 3 | Exponent of the APB1 ratio in effect |
| apb2_shift | output | 3 | Exponent of the APB2 ratio in effect |

## Verification
The assertions rely on two things. First, reset is held long enough for at least one clock edge to reach the counters. Second, `cfg_data` is a known value whenever `cfg_we` is high, so the decoded exponent is always a legal value. The stimulus drives every input on the falling edge, keeps `cfg_we` high for exactly one cycle per write, and drives only fully specified words. Some writes land in the middle of a long AHB period. Others land on the cycle of a terminal count.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    localparam int AHB_FIELD_W = 4;
    localparam int APB_FIELD_W = 3;
    localparam int CFG_W       = AHB_FIELD_W + 2 * APB_FIELD_W;
    localparam int AHB_SHIFT_W = 4;
    localparam int APB_SHIFT_W = 3;
    localparam int AHB_MAX_SH  = 9;
    localparam int APB_MAX_SH  = 4;
    localparam int NUM_APB     = 2;

    typedef struct packed {
        logic [APB_FIELD_W-1:0] apb2;
        logic [APB_FIELD_W-1:0] apb1;
        logic [AHB_FIELD_W-1:0] ahb;
    } busclk_cfg_t;

    // AHB: upper half of the code space skips exponent 5.
    function automatic logic [AHB_SHIFT_W-1:0] ahb_code_to_shift(input logic [AHB_FIELD_W-1:0] code);
        logic [AHB_SHIFT_W-1:0] sh;
        if (!code[3])
            sh = '0;
        else if (!code[2])
            sh = AHB_SHIFT_W'({2'b00, code[1:0]} + 4'd1);
        else
            sh = AHB_SHIFT_W'({2'b00, code[1:0]} + 4'd6);
        return sh;
    endfunction

    function automatic logic [APB_SHIFT_W-1:0] apb_code_to_shift(input logic [APB_FIELD_W-1:0] code);
        logic [APB_SHIFT_W-1:0] sh;
        if (!code[2])
            sh = '0;
        else
            sh = APB_SHIFT_W'({1'b0, code[1:0]} + 3'd1);
        return sh;
    endfunction

endpackage

// File: rtl/busclk_cfg.sv
module busclk_cfg
    import busclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output busclk_cfg_t        cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (we)
            cfg_q <= busclk_cfg_t'(wdata);
    end
endmodule

// File: rtl/busclk_div.sv
module busclk_div #(
    parameter int SHIFT_W = 4,
    parameter int MAX_SH  = 9,
    localparam int CNT_W  = (MAX_SH < 1) ? 1 : MAX_SH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_in,
    input  logic [SHIFT_W-1:0] shift_req,
    output logic               tick_out,
    output logic [SHIFT_W-1:0] shift_cur
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             at_term;

    always_comb begin
        term    = CNT_W'((32'd1 << shift_cur) - 32'd1);
        at_term = (cnt == term);
    end

    assign tick_out = tick_in & at_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            shift_cur <= '0;
        end else if (tick_in) begin
            if (at_term) begin
                cnt       <= '0;
                shift_cur <= shift_req;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/busclk_prescaler.sv
module busclk_prescaler
    import busclk_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [CFG_W-1:0]       cfg_data,
    output logic                   ahb_en,
    output logic                   apb1_en,
    output logic                   apb2_en,
    output logic [AHB_SHIFT_W-1:0] ahb_shift,
    output logic [APB_SHIFT_W-1:0] apb1_shift,
    output logic [APB_SHIFT_W-1:0] apb2_shift
);
    busclk_cfg_t            cfg_q;
    logic [APB_SHIFT_W-1:0] apb_req [NUM_APB];
    logic [APB_SHIFT_W-1:0] apb_cur [NUM_APB];
    logic [NUM_APB-1:0]     apb_tick;

    busclk_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_data),
        .cfg_q (cfg_q)
    );

    busclk_div #(.SHIFT_W(AHB_SHIFT_W), .MAX_SH(AHB_MAX_SH)) u_ahb_div (
        .clk       (clk),
        .rst       (rst),
        .tick_in   (1'b1),
        .shift_req (ahb_code_to_shift(cfg_q.ahb)),
        .tick_out  (ahb_en),
        .shift_cur (ahb_shift)
    );

    assign apb_req[0] = apb_code_to_shift(cfg_q.apb1);
    assign apb_req[1] = apb_code_to_shift(cfg_q.apb2);

    for (genvar g = 0; g < NUM_APB; g++) begin : g_apb
        busclk_div #(.SHIFT_W(APB_SHIFT_W), .MAX_SH(APB_MAX_SH)) u_apb_div (
            .clk       (clk),
            .rst       (rst),
            .tick_in   (ahb_en),
            .shift_req (apb_req[g]),
            .tick_out  (apb_tick[g]),
            .shift_cur (apb_cur[g])
        );
    end

    assign apb1_en    = apb_tick[0];
    assign apb2_en    = apb_tick[1];
    assign apb1_shift = apb_cur[0];
    assign apb2_shift = apb_cur[1];
endmodule

// File: rtl/busclk_prescaler_chk.sv
module busclk_prescaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       ahb_en,
    input logic       apb1_en,
    input logic       apb2_en,
    input logic [3:0] ahb_shift,
    input logic [2:0] apb1_shift,
    input logic [2:0] apb2_shift
);
    AST_APB1_INSIDE_AHB: assert property (@(posedge clk) disable iff (rst) apb1_en |-> ahb_en); // R6
    AST_APB2_INSIDE_AHB: assert property (@(posedge clk) disable iff (rst) apb2_en |-> ahb_en); // R6
    AST_OUT_OF_RESET_DIV1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ahb_en && apb1_en && apb2_en && ahb_shift == 4'd0)); // R1
    AST_AHB_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(ahb_en) |-> $stable(ahb_shift)); // R9
    AST_APB1_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(apb1_en) |-> $stable(apb1_shift)); // R8
    AST_AHB_NO_DIV32: assert property (@(posedge clk) disable iff (rst)
        (ahb_shift != 4'd5) && (ahb_shift <= 4'd9)); // R3
    AST_APB_RANGE: assert property (@(posedge clk) disable iff (rst)
        (apb1_shift <= 3'd4) && (apb2_shift <= 3'd4)); // R4
endmodule

bind busclk_prescaler busclk_prescaler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ahb_en     (ahb_en),
    .apb1_en    (apb1_en),
    .apb2_en    (apb2_en),
    .ahb_shift  (ahb_shift),
    .apb1_shift (apb1_shift),
    .apb2_shift (apb2_shift)
);

// File: tb/busclk_prescaler_test.sv
module busclk_prescaler_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_data = '0;
    logic       ahb_en, apb1_en, apb2_en;
    logic [3:0] ahb_shift;
    logic [2:0] apb1_shift, apb2_shift;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    busclk_prescaler uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .ahb_en(ahb_en), .apb1_en(apb1_en), .apb2_en(apb2_en),
        .ahb_shift(ahb_shift), .apb1_shift(apb1_shift), .apb2_shift(apb2_shift)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ratio tables written from the requirements (R2, R4).
    function automatic int ahb_ratio(input int code);
        case (code)
            8: return 2;   9: return 4;   10: return 8;   11: return 16;
            12: return 64; 13: return 128; 14: return 256; 15: return 512;
            default: return 1;
        endcase
    endfunction
    function automatic int apb_ratio(input int code);
        case (code)
            4: return 2; 5: return 4; 6: return 8; 7: return 16;
            default: return 1;
        endcase
    endfunction
    function automatic int log2i(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // Behavioural reference: ratio in effect plus cycles elapsed in each domain.
    int m_cfg = 0;
    int m_hr = 1, m_hc = 0;
    int m_p1r = 1, m_p1c = 0;
    int m_p2r = 1, m_p2c = 0;

    always @(posedge clk) begin
        bit hit;
        if (rst) begin
            m_cfg = 0; m_hr = 1; m_hc = 0;
            m_p1r = 1; m_p1c = 0; m_p2r = 1; m_p2c = 0;
        end else begin
            hit = (m_hc == m_hr - 1);
            if (hit) begin
                if (m_p1c == m_p1r - 1) begin m_p1c = 0; m_p1r = apb_ratio((m_cfg >> 4) & 7); end
                else m_p1c++;
                if (m_p2c == m_p2r - 1) begin m_p2c = 0; m_p2r = apb_ratio((m_cfg >> 7) & 7); end
                else m_p2c++;
                m_hc = 0; m_hr = ahb_ratio(m_cfg & 15);
            end else begin
                m_hc++;
            end
            if (cfg_we) m_cfg = int'(cfg_data);
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        bit eh;
        cyc++;
        if (!rst && !done) begin
            eh = (m_hc == m_hr - 1);
            check("R2 ahb_en", int'(ahb_en), int'(eh));
            check("R5 apb1_en", int'(apb1_en), int'(eh && (m_p1c == m_p1r - 1)));
            check("R5 apb2_en", int'(apb2_en), int'(eh && (m_p2c == m_p2r - 1)));
            check("R9 ahb_shift", int'(ahb_shift), log2i(m_hr));
            check("R9 apb1_shift", int'(apb1_shift), log2i(m_p1r));
            check("R9 apb2_shift", int'(apb2_shift), log2i(m_p2r));
        end
    end

    task automatic write_cfg(input int ahb, input int p1, input int p2);
        cfg_data = 10'((p2 << 7) | (p1 << 4) | ahb);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ahb();
        do @(negedge clk); while (!ahb_en);
    endtask

    task automatic count_pulses(input int n, output int h, output int a1, output int a2);
        h = 0; a1 = 0; a2 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            h += int'(ahb_en); a1 += int'(apb1_en); a2 += int'(apb2_en);
        end
    endtask

    initial begin
        int h, a1, a2, gap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle out of reset
        check("R1 ahb_en", int'(ahb_en), 1);
        check("R1 apb1_en", int'(apb1_en), 1);
        check("R1 apb2_en", int'(apb2_en), 1);
        check("R1 ahb_shift", int'(ahb_shift), 0);

        // R7 / R2 / R5: AHB /64 (1100), APB1 /2 (100), APB2 /16 (111)
        write_cfg(12, 4, 7);
        repeat (3000) @(negedge clk);
        wait_ahb();
        count_pulses(1024, h, a1, a2);
        check("R7 R2 ahb pulses /64", h, 16);
        check("R5 apb1 pulses /128", a1, 8);
        check("R5 apb2 pulses /1024", a2, 1);
        check("R3 code 1100 exponent", int'(ahb_shift), 6);

        // R3: code 1011 is /16 (exponent 4)
        write_cfg(11, 0, 0);
        repeat (200) @(negedge clk);
        check("R3 code 1011 exponent", int'(ahb_shift), 4);
        wait_ahb();
        count_pulses(64, h, a1, a2);
        check("R3 ahb pulses /16", h, 4);
        check("R4 apb1 code 000 follows ahb", a1, 4);

        // R4: codes with bit 2 clear are /1; 101 is /4
        write_cfg(0, 3, 5);
        repeat (100) @(negedge clk);
        count_pulses(40, h, a1, a2);
        check("R4 ahb /1", h, 40);
        check("R4 apb1 code 011 /1", a1, 40);
        check("R4 apb2 code 101 /4", a2, 10);

        // R8: switch from /512 to /2 mid-period; running period keeps 512
        write_cfg(15, 0, 0);
        wait_ahb();
        wait_ahb();
        repeat (10) @(negedge clk);
        write_cfg(8, 0, 0);
        gap = 11;
        do begin @(negedge clk); gap++; end while (!ahb_en);
        check("R8 old period completes", gap, 512);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!ahb_en);
        check("R8 new period", gap, 2);
        check("R9 readback after switch", int'(ahb_shift), 1);

        // R6: APB strobes inside AHB strobes across mixed settings
        write_cfg(9, 6, 4);
        repeat (400) @(negedge clk);
        h = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((apb1_en || apb2_en) && !ahb_en) h++;
        end
        check("R6 apb without ahb", h, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule